// File: doc/BRIEF.md
# Periodic Interrupt Timer Channel

This block is one 16-bit timer channel. An up-counter advances by one on each cycle where the one-cycle `tick_i` pulse is high, but only while counting is switched on. `tick_i` comes from a separate clock-select block. A restart request can come from four sources: a software command, a synchronisation pulse shared by all channels, a qualified edge on an external pin, or the counter reaching the period value. A restart does not clear the counter at once. The counter is loaded with zero on the next tick after the request. Because of this, a period value of N gives a repeating cycle of N+1 ticks.

Two sticky events are recorded: counter wrap-around and period match. Each event has a mask bit. The interrupt output is a level that stays high while any unmasked event is pending. Reading the status word clears the events.

A small FSM controls counting and has three states:
- OFF: counting is stopped.
- RUN: counting is active.
- PEND: counting is active and a restart is waiting for the next tick.

Its transitions are:
- start: OFF→RUN, on an enable command without a disable command.
- halt: RUN→OFF or PEND→OFF, on a disable command.
- arm: RUN→PEND, on any restart request.
- reload: PEND→RUN, on a tick with no new request.
- rearm: PEND→PEND, on a tick together with a new request.

Register map (the address is `wr_addr` or `rd_addr`):
- 0: command register, write only.
- 1: mode register.
- 2: period register.
- 3: counter value, read only.
- 4: status register, read clears it.
- 5: mask-set register; a read returns the mask.
- 6: mask-clear register.

Top module: `tmr_chan_top`

## Requirements
- R1: After reset, the counter reads 0, the period reads 0xFFFF, and the mode, status and mask read 0. The state is OFF and `irq_o` is low.
- R2: In RUN, each cycle with `tick_i` high adds one to the counter. In OFF, ticks leave the counter unchanged. Writing command bit 0 (enable) sets status bit 2, which reads 1 in RUN and PEND.
- R3: A tick that finds the counter at 0xFFFF in RUN loads 0 and sets status bit 0 (wrap event).
- R4: Writing command bit 2 (software restart) leaves the counter unchanged until the next tick. That tick loads 0, and later ticks count up from 0.
- R5: A one-cycle pulse on `sync_i` has the same effect as a software restart.
- R6: A tick that loads a counter value equal to the period sets status bit 1 (match event). When mode bit 0 is set, the match also requests a restart, so the counter repeats every period+1 ticks.
- R7: `ext_i` passes through a two-stage synchroniser. Its edges request a restart only while mode bit 1 is set. Mode bit 2 selects the edge: 0 selects rising and 1 selects falling.
- R8: Command bit 1 (disable) moves the FSM to OFF and wins over command bit 0 in the same write. A restart request made while in OFF is dropped.
- R9: A status read returns the event bits and clears them at the next clock edge. An event that occurs in the same cycle as the read stays set.
- R10: Writing ones to address 5 sets mask bits and writing ones to address 6 clears them. Mask bit 0 is for wrap and mask bit 1 is for match. `irq_o` is high exactly while some event bit is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle count enable from the clock-select block |
| sync_i | input | 1 | Shared restart pulse |
| ext_i | input | 1 | External restart source, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Level interrupt |

## Verification
The wrap event is the hardest case to reach from the ports, because the counter can only be moved by ticks. The bench restarts the counter at zero and then holds `tick_i` high for 65535 consecutive cycles. It reads the value 0xFFFF before the final tick, then checks the wrap bit and also confirms that the interrupt stays low while the wrap event is masked. The read-versus-event collision is built by placing a status read in the same cycle as the tick that lands on the period value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } tmr_state_e;

    localparam int ADDR_W = 3;
    localparam int NFLAG  = 2;
    localparam int MODE_W = 3;

    localparam logic [ADDR_W-1:0] A_CMD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER   = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MSET  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MCLR  = 3'd6;

    // command bits
    localparam int CB_START = 0;
    localparam int CB_STOP  = 1;
    localparam int CB_RST   = 2;
    // mode bits
    localparam int MB_PERRST = 0;
    localparam int MB_EXTEN  = 1;
    localparam int MB_EXTNEG = 2;
    // status bits
    localparam int FB_WRAP  = 0;
    localparam int FB_MATCH = 1;
    localparam int SB_ACT   = 2;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic enable,
    input  logic neg_sel,
    output logic req_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_q;

    // chain_q[0] takes the raw pin, chain_q[STAGES-1] is the synchronised
    // level, chain_q[STAGES] is that level one cycle older.
    generate
        for (genvar g = 0; g < LEN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= ext_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    logic now_lvl, old_lvl;
    assign now_lvl = chain_q[STAGES-1];
    assign old_lvl = chain_q[STAGES];

    always_comb begin
        if (neg_sel) req_o = enable & old_lvl & ~now_lvl;
        else         req_o = enable & now_lvl & ~old_lvl;
    end
endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       restart,
    input  logic       tick,
    output tmr_state_e state_o,
    output logic       cnt_inc,
    output logic       cnt_zero,
    output logic       active
);
    tmr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                // start: a disable in the same write wins
                if (start && !stop) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (stop)         state_d = ST_OFF;   // halt
                else if (restart) state_d = ST_PEND;  // arm
            end
            ST_PEND: begin
                if (stop)                  state_d = ST_OFF;  // halt
                else if (tick && !restart) state_d = ST_RUN;  // reload
                // rearm: tick with new request stays in PEND
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        cnt_inc  = 1'b0;
        cnt_zero = 1'b0;
        active   = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_RUN:  begin cnt_inc  = tick; active = 1'b1; end
            ST_PEND: begin cnt_zero = tick; active = 1'b1; end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         zero,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt_o,
    output logic         wrap_evt,
    output logic         match_evt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q, cnt_next;
    logic         step;

    assign step     = inc | zero;
    assign cnt_next = zero ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= cnt_next;
    end

    assign wrap_evt  = inc & (cnt_q == TOP);
    assign match_evt = step & (cnt_next == period);
    assign cnt_o     = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      cnt,
    input  logic              active,
    input  logic              wrap_evt,
    input  logic              match_evt,
    output logic [W-1:0]      rd_data,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_rst,
    output logic              per_rst_en,
    output logic              ext_en,
    output logic              ext_neg,
    output logic [W-1:0]      period_o,
    output logic [NFLAG-1:0]  flags_o,
    output logic              irq_o
);
    logic [MODE_W-1:0] mode_q;
    logic [W-1:0]      period_q;
    logic [NFLAG-1:0]  flag_q, mask_q, evt;
    logic              wr_cmd, wr_mode, wr_per, wr_mset, wr_mclr, stat_rd;

    assign wr_cmd  = wr_en && (wr_addr == A_CMD);
    assign wr_mode = wr_en && (wr_addr == A_MODE);
    assign wr_per  = wr_en && (wr_addr == A_PER);
    assign wr_mset = wr_en && (wr_addr == A_MSET);
    assign wr_mclr = wr_en && (wr_addr == A_MCLR);
    assign stat_rd = rd_en && (rd_addr == A_STAT);

    assign cmd_start = wr_cmd & wr_data[CB_START];
    assign cmd_stop  = wr_cmd & wr_data[CB_STOP];
    assign cmd_rst   = wr_cmd & wr_data[CB_RST];

    always_comb begin
        evt           = '0;
        evt[FB_WRAP]  = wrap_evt;
        evt[FB_MATCH] = match_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            period_q <= {W{1'b1}};
        end else begin
            if (wr_mode) mode_q   <= wr_data[MODE_W-1:0];
            if (wr_per)  period_q <= wr_data;
        end
    end

    // sticky events: a new event outranks the clear of a status read
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= evt | (flag_q & ~{NFLAG{stat_rd}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mset) mask_q <= mask_q | wr_data[NFLAG-1:0];
        else if (wr_mclr) mask_q <= mask_q & ~wr_data[NFLAG-1:0];
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_MODE:  rd_data[MODE_W-1:0] = mode_q;
            A_PER:   rd_data = period_q;
            A_COUNT: rd_data = cnt;
            A_STAT: begin
                rd_data[NFLAG-1:0] = flag_q;
                rd_data[SB_ACT]    = active;
            end
            A_MSET:  rd_data[NFLAG-1:0] = mask_q;
            default: rd_data = '0;
        endcase
    end

    assign per_rst_en = mode_q[MB_PERRST];
    assign ext_en     = mode_q[MB_EXTEN];
    assign ext_neg    = mode_q[MB_EXTNEG];
    assign period_o   = period_q;
    assign flags_o    = flag_q;
    assign irq_o      = |(flag_q & mask_q);
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sync_i,
    input  logic              ext_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_o
);
    tmr_state_e       state;
    logic             cmd_start, cmd_stop, cmd_rst;
    logic             per_rst_en, ext_en, ext_neg, ext_req;
    logic             cnt_inc, cnt_zero, active;
    logic             wrap_evt, match_evt, restart;
    logic [CNT_W-1:0] cnt_q, period_q;
    logic [NFLAG-1:0] flag_q;

    assign restart = cmd_rst | sync_i | ext_req | (match_evt & per_rst_en);

    tmr_ext_sync #(.STAGES(SYNC_STAGES)) i_ext (
        .clk(clk), .rst_n(rst_n), .ext_i(ext_i),
        .enable(ext_en), .neg_sel(ext_neg), .req_o(ext_req)
    );

    tmr_ctrl_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .start(cmd_start), .stop(cmd_stop),
        .restart(restart), .tick(tick_i), .state_o(state),
        .cnt_inc(cnt_inc), .cnt_zero(cnt_zero), .active(active)
    );

    tmr_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .zero(cnt_zero),
        .period(period_q), .cnt_o(cnt_q),
        .wrap_evt(wrap_evt), .match_evt(match_evt)
    );

    tmr_regs #(.W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .cnt(cnt_q), .active(active),
        .wrap_evt(wrap_evt), .match_evt(match_evt),
        .rd_data(rd_data),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_rst(cmd_rst),
        .per_rst_en(per_rst_en), .ext_en(ext_en), .ext_neg(ext_neg),
        .period_o(period_q), .flags_o(flag_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             stop_req,
    input tmr_state_e       state,
    input logic [W-1:0]     cnt,
    input logic [NFLAG-1:0] flags,
    input logic             irq
);
    // R2: the counter moves only on a tick
    a_r2_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    // R2: ticks in OFF are ignored
    a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_OFF) |=> $stable(cnt));

    // R3: a wrap sets the wrap event
    a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_RUN && cnt == {W{1'b1}}) |=> (flags[FB_WRAP] && cnt == '0));

    // R4: a tick in PEND lands on zero
    a_r4_pend_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_PEND) |=> cnt == '0);

    // R8: disable always wins
    a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> state == ST_OFF);

    // R10: interrupt only with a pending event
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags != '0);
endmodule

bind tmr_chan_top tmr_chan_chk #(.W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick_i),
    .stop_req(wr_en && wr_addr == tmr_pkg::A_CMD && wr_data[tmr_pkg::CB_STOP]),
    .state(state), .cnt(cnt_q), .flags(flag_q), .irq(irq_o)
);

// File: tb/test_tmr_chan_top.sv
module test_tmr_chan_top;
    localparam logic [2:0] AD_CMD = 3'd0, AD_MODE = 3'd1, AD_PER = 3'd2,
                           AD_CNT = 3'd3, AD_STAT = 3'd4, AD_MSET = 3'd5,
                           AD_MCLR = 3'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0, sync_i = 1'b0, ext_i = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_chan_top i_tmr_chan_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sync_i(sync_i),
        .ext_i(ext_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic expect_irq(input string req, input logic exp);
        #1 check(req, {15'd0, irq_o}, {15'd0, exp});
    endtask

    task automatic t_reset;
        expect_reg("R1 count", AD_CNT, 16'h0000);
        expect_reg("R1 period", AD_PER, 16'hFFFF);
        expect_reg("R1 mode", AD_MODE, 16'h0000);
        expect_reg("R1 status", AD_STAT, 16'h0000);
        expect_reg("R1 mask", AD_MSET, 16'h0000);
        expect_irq("R1 irq", 1'b0);
    endtask

    task automatic t_count;
        ticks(4);
        expect_reg("R2 off ignores ticks", AD_CNT, 16'd0);
        wr(AD_CMD, 16'h0001);
        expect_reg("R2 active bit", AD_STAT, 16'h0004);
        ticks(5);
        expect_reg("R2 counts ticks", AD_CNT, 16'd5);
    endtask

    task automatic t_sw_restart;
        wr(AD_CMD, 16'h0004);
        idle(3);
        expect_reg("R4 holds until tick", AD_CNT, 16'd5);
        ticks(1);
        expect_reg("R4 zero on tick", AD_CNT, 16'd0);
        ticks(2);
        expect_reg("R4 counts after", AD_CNT, 16'd2);
    endtask

    task automatic t_sync;
        @(negedge clk); sync_i = 1'b1;
        @(negedge clk); sync_i = 1'b0;
        idle(2);
        expect_reg("R5 holds until tick", AD_CNT, 16'd2);
        ticks(1);
        expect_reg("R5 zero on tick", AD_CNT, 16'd0);
    endtask

    task automatic t_period;
        wr(AD_PER, 16'd3);
        wr(AD_MODE, 16'h0001);
        expect_reg("R6 status clean", AD_STAT, 16'h0004);
        ticks(3);
        expect_reg("R6 match flag", AD_STAT, 16'h0006);
        expect_reg("R6 at period", AD_CNT, 16'd3);
        ticks(1);
        expect_reg("R6 restart after match", AD_CNT, 16'd0);
        ticks(4);
        expect_reg("R6 period+1 cycle", AD_CNT, 16'd0);
        wr(AD_MODE, 16'h0000);
        expect_reg("R9 read returns flag", AD_STAT, 16'h0006);
        expect_reg("R9 read cleared flag", AD_STAT, 16'h0004);
    endtask

    task automatic t_irq;
        wr(AD_MSET, 16'h0002);
        expect_irq("R10 no event no irq", 1'b0);
        ticks(3);
        expect_irq("R10 irq on match", 1'b1);
        wr(AD_MCLR, 16'h0002);
        expect_irq("R10 masked", 1'b0);
        expect_reg("R10 flag kept while masked", AD_STAT, 16'h0006);
        wr(AD_MSET, 16'h0002);
        wr(AD_CMD, 16'h0004);
        ticks(1);
        ticks(3);
        expect_irq("R10 irq again", 1'b1);
        expect_reg("R9 read", AD_STAT, 16'h0006);
        expect_irq("R9 irq dropped after read", 1'b0);
    endtask

    task automatic t_collision;
        logic [15:0] v;
        wr(AD_CMD, 16'h0004);
        ticks(1);
        ticks(2);
        @(negedge clk);
        tick_i = 1'b1; rd_en = 1'b1; rd_addr = AD_STAT;
        #1 v = rd_data;
        @(negedge clk);
        tick_i = 1'b0; rd_en = 1'b0;
        check("R9 read before event", v, 16'h0004);
        expect_irq("R9 event beats clear irq", 1'b1);
        expect_reg("R9 event beats clear", AD_STAT, 16'h0006);
    endtask

    task automatic pulse_ext;
        @(negedge clk); ext_i = 1'b1;
        idle(3);
        ext_i = 1'b0;
        idle(6);
    endtask

    task automatic t_ext;
        wr(AD_PER, 16'hFFFF);
        pulse_ext();
        ticks(1);
        expect_reg("R7 ignored when disabled", AD_CNT, 16'd4);
        wr(AD_MODE, 16'h0002);
        pulse_ext();
        expect_reg("R7 holds until tick", AD_CNT, 16'd4);
        ticks(1);
        expect_reg("R7 rising restarts", AD_CNT, 16'd0);
        ticks(2);
        wr(AD_MODE, 16'h0006);
        @(negedge clk); ext_i = 1'b1;
        idle(6);
        ticks(1);
        expect_reg("R7 rising ignored in falling mode", AD_CNT, 16'd3);
        @(negedge clk); ext_i = 1'b0;
        idle(6);
        ticks(1);
        expect_reg("R7 falling restarts", AD_CNT, 16'd0);
        wr(AD_MODE, 16'h0000);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        rd(AD_STAT, v);
        ticks(65535);
        expect_reg("R3 reaches top", AD_CNT, 16'hFFFF);
        expect_reg("R3 no wrap yet", AD_STAT, 16'h0006);
        ticks(1);
        expect_reg("R3 wrapped to zero", AD_CNT, 16'h0000);
        expect_irq("R10 wrap masked", 1'b0);
        expect_reg("R3 wrap flag", AD_STAT, 16'h0005);
    endtask

    task automatic t_stop;
        ticks(2);
        wr(AD_CMD, 16'h0003);
        expect_reg("R8 disable wins", AD_STAT, 16'h0000);
        ticks(3);
        expect_reg("R8 off holds", AD_CNT, 16'd2);
        wr(AD_CMD, 16'h0004);
        wr(AD_CMD, 16'h0001);
        ticks(1);
        expect_reg("R8 restart in off dropped", AD_CNT, 16'd3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_sw_restart();
        t_sync();
        t_period();
        t_irq();
        t_collision();
        t_ext();
        t_wrap();
        t_stop();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule